// File: doc/BRIEF.md
# Dual Stack Pointer RAM Controller

This block owns a small byte-wide data RAM that two stacks share. The program stack keeps return addresses: a call stores a two-byte address at the program pointer and moves the pointer up by two, and a return moves it back down by two and delivers the stored address. The data stack keeps single bytes. A push first moves the data pointer down by one and then writes at the new address. A pop reads at the current address and then moves the pointer up by one. Firmware can load either pointer directly through a load port.

The highest bytes of the RAM (16 bytes with the default parameters, 0x70 to 0x7F) are set aside as two 8-byte endpoint buffers. Both pointers reset to zero. The program stack therefore grows upward from the bottom of the RAM. An unprepared data stack wraps on its first push into the last buffer byte. A one-cycle flag reports every data-stack access that lands in the buffer region, so a misplaced data stack can be seen. Loading the data pointer with 0x70 moves the first push to 0x6F and leaves the whole buffer region free.

Top module: `dsr_stack_ctrl`

## Requirements
- R1: After reset both pointers read 0x00, and the pop data, return address and buffer flag outputs read zero.
- R2: A call writes the low byte of `ret_addr_i` at the program pointer and the high byte at the pointer plus one, and the program pointer reads two higher after the clock edge.
- R3: A return lowers the program pointer by two. After the same edge `ret_addr_o` holds {byte at new pointer + 1, byte at new pointer}, with the high byte from the higher address.
- R4: A push lowers the data pointer by one and writes `push_data_i` at the lowered address.
- R5: A pop places the byte at the current data pointer on `pop_data_o` after the edge and raises the pointer by one. `pop_data_o` holds its value until the next pop that is carried out.
- R6: All pointer arithmetic wraps modulo 128. A push at 0x00 writes 0x7F, a return at 0x00 gives 0x7E, and a call at 0x7E writes 0x7E and 0x7F and leaves the pointer at 0x00.
- R7: `ep_hit_o` is high for exactly the one cycle after a push or pop whose byte address lies in 0x70 to 0x7F, and low after every other cycle.
- R8: With the data pointer loaded to 0x70, the next push writes 0x6F and does not raise `ep_hit_o`.
- R9: When a call or return occurs in the same cycle as a push or pop, the push or pop is dropped. The data pointer is unchanged, nothing is written for it, `pop_data_o` holds, and `ep_hit_o` stays low.
- R10: A push together with a pop acts as the push alone. A call together with a return acts as the call alone.
- R11: A pointer load takes `ld_val_i` into the chosen pointer at the edge. Any stack operation on that pointer in the same cycle is dropped, including its RAM write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| call_i | input | 1 | Call strobe: store return address, program pointer +2 |
| ret_i | input | 1 | Return strobe: program pointer -2, read return address |
| push_i | input | 1 | Push strobe: data pointer -1, then write |
| pop_i | input | 1 | Pop strobe: read, then data pointer +1 |
| push_data_i | input | 8 | Byte written by a push |
| ret_addr_i | input | 16 | Return address stored by a call |
| ld_psp_i | input | 1 | Load the program pointer from `ld_val_i` |
| ld_dsp_i | input | 1 | Load the data pointer from `ld_val_i` |
| ld_val_i | input | 7 | Pointer load value |
| pop_data_o | output | 8 | Byte delivered by the last pop |
| ret_addr_o | output | 16 | Address delivered by the last return |
| psp_o | output | 7 | Program stack pointer |
| dsp_o | output | 7 | Data stack pointer |
| ep_hit_o | output | 1 | Last data-stack access fell in the endpoint buffer region |

## Verification
A program-stack operation (call or return) and a data-stack operation (push or pop) can be requested in the same cycle and compete for the RAM write port. The bench provokes this in two ways. It first stores a known byte under the data pointer and then issues a push of a different byte together with a call. Later it issues a pop together with a return. It judges the outcome by the data pointer staying where it was, the flag staying low and `pop_data_o` holding. A later pop must still return the earlier byte, while the call or return completes with the expected pointer and return address.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
   // Per-cycle action applied to one stack pointer
   typedef enum logic [1:0] {
      P_HOLD = 2'd0,
      P_UP   = 2'd1,
      P_DOWN = 2'd2,
      P_LOAD = 2'd3
   } ptr_op_e;
endpackage

// File: rtl/dsr_ptr.sv
module dsr_ptr
   import dsr_pkg::*;
#(
   parameter int AW   = 7,
   parameter int STEP = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  ptr_op_e       op,
   input  logic [AW-1:0] ld_val,
   output logic [AW-1:0] ptr
);
   localparam logic [AW-1:0] STEP_V = AW'(STEP);

   if (STEP < 1 || STEP >= (1 << AW)) begin : g_bad_step
      $error("dsr_ptr: STEP out of range");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
      end else begin
         unique case (op)
            P_UP:    ptr <= ptr + STEP_V;
            P_DOWN:  ptr <= ptr - STEP_V;
            P_LOAD:  ptr <= ld_val;
            default: ptr <= ptr;
         endcase
      end
   end
endmodule

// File: rtl/dsr_byte_ram.sv
module dsr_byte_ram #(
   parameter int AW  = 7,
   parameter int DW  = 8,
   parameter int NWR = 2,
   parameter int NRD = 3
) (
   input  logic                     clk,
   input  logic [NWR-1:0]           wr_en,
   input  logic [NWR-1:0][AW-1:0]   wr_addr,
   input  logic [NWR-1:0][DW-1:0]   wr_data,
   input  logic [NRD-1:0][AW-1:0]   rd_addr,
   output logic [NRD-1:0][DW-1:0]   rd_data
);
   localparam int DEPTH = 1 << AW;

   if (NWR < 1 || NRD < 1) begin : g_bad_ports
      $error("dsr_byte_ram: needs at least one read and one write port");
   end

   logic [DW-1:0] mem [DEPTH];

   // Higher-numbered write port wins on an address clash
   always_ff @(posedge clk) begin
      for (int p = 0; p < NWR; p++) begin
         if (wr_en[p]) mem[wr_addr[p]] <= wr_data[p];
      end
   end

   for (genvar r = 0; r < NRD; r++) begin : g_rd
      assign rd_data[r] = mem[rd_addr[r]];
   end
endmodule

// File: rtl/dsr_region.sv
module dsr_region #(
   parameter int AW        = 7,
   parameter int BUF_BYTES = 16
) (
   input  logic [AW-1:0] addr,
   output logic          hit
);
   localparam logic [AW-1:0] BASE = AW'((1 << AW) - BUF_BYTES);

   if ((BUF_BYTES & (BUF_BYTES - 1)) == 0) begin : g_pow2
      // Aligned top region: only the upper address bits matter
      localparam int LW = $clog2(BUF_BYTES);
      assign hit = &addr[AW-1:LW];
   end else begin : g_cmp
      assign hit = (addr >= BASE);
   end
endmodule

// File: rtl/dsr_stack_ctrl.sv
module dsr_stack_ctrl
   import dsr_pkg::*;
#(
   parameter int AW        = 7,
   parameter int DW        = 8,
   parameter int BUF_BYTES = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            call_i,
   input  logic            ret_i,
   input  logic            push_i,
   input  logic            pop_i,
   input  logic [DW-1:0]   push_data_i,
   input  logic [2*DW-1:0] ret_addr_i,
   input  logic            ld_psp_i,
   input  logic            ld_dsp_i,
   input  logic [AW-1:0]   ld_val_i,
   output logic [DW-1:0]   pop_data_o,
   output logic [2*DW-1:0] ret_addr_o,
   output logic [AW-1:0]   psp_o,
   output logic [AW-1:0]   dsp_o,
   output logic            ep_hit_o
);
   localparam int RW = 2 * DW;
   localparam logic [AW-1:0] ONE = AW'(1);
   localparam logic [AW-1:0] TWO = AW'(2);

   if (AW < 2 || DW < 1) begin : g_bad_width
      $error("dsr_stack_ctrl: AW must be at least 2 and DW at least 1");
   end
   if (BUF_BYTES < 1 || BUF_BYTES >= (1 << AW)) begin : g_bad_buf
      $error("dsr_stack_ctrl: BUF_BYTES must lie inside the RAM");
   end

   ptr_op_e p_op, d_op;
   logic    stk_req;
   logic    do_call, do_ret, do_push, do_pop;

   assign stk_req = call_i | ret_i;

   // Program stack decode: load > call > return
   always_comb begin
      p_op = P_HOLD;
      if (ld_psp_i)    p_op = P_LOAD;
      else if (call_i) p_op = P_UP;
      else if (ret_i)  p_op = P_DOWN;
   end

   // Data stack decode: load > (blocked by program stack) > push > pop
   always_comb begin
      d_op = P_HOLD;
      if (ld_dsp_i)     d_op = P_LOAD;
      else if (stk_req) d_op = P_HOLD;
      else if (push_i)  d_op = P_DOWN;
      else if (pop_i)   d_op = P_UP;
   end

   assign do_call = (p_op == P_UP);
   assign do_ret  = (p_op == P_DOWN);
   assign do_push = (d_op == P_DOWN);
   assign do_pop  = (d_op == P_UP);

   dsr_ptr #(.AW(AW), .STEP(2)) u_psp (
      .clk(clk), .rst_n(rst_n), .op(p_op), .ld_val(ld_val_i), .ptr(psp_o)
   );
   dsr_ptr #(.AW(AW), .STEP(1)) u_dsp (
      .clk(clk), .rst_n(rst_n), .op(d_op), .ld_val(ld_val_i), .ptr(dsp_o)
   );

   logic [AW-1:0] push_addr;
   assign push_addr = dsp_o - ONE;

   logic [1:0]         wr_en;
   logic [1:0][AW-1:0] wr_addr;
   logic [1:0][DW-1:0] wr_data;
   logic [2:0][AW-1:0] rd_addr;
   logic [2:0][DW-1:0] rd_data;

   // Port 0: call low byte or push byte; port 1: call high byte
   assign wr_en[0]   = do_call | do_push;
   assign wr_addr[0] = do_call ? psp_o : push_addr;
   assign wr_data[0] = do_call ? ret_addr_i[DW-1:0] : push_data_i;
   assign wr_en[1]   = do_call;
   assign wr_addr[1] = psp_o + ONE;
   assign wr_data[1] = ret_addr_i[RW-1:DW];

   assign rd_addr[0] = dsp_o;
   assign rd_addr[1] = psp_o - TWO;
   assign rd_addr[2] = psp_o - ONE;

   dsr_byte_ram #(.AW(AW), .DW(DW), .NWR(2), .NRD(3)) u_ram (
      .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   logic [AW-1:0] acc_addr;
   logic          acc_in_buf;
   assign acc_addr = do_push ? push_addr : dsp_o;

   dsr_region #(.AW(AW), .BUF_BYTES(BUF_BYTES)) u_region (
      .addr(acc_addr), .hit(acc_in_buf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pop_data_o <= '0;
         ret_addr_o <= '0;
         ep_hit_o   <= 1'b0;
      end else begin
         if (do_pop) pop_data_o <= rd_data[0];
         if (do_ret) ret_addr_o <= {rd_data[2], rd_data[1]};
         ep_hit_o <= (do_push | do_pop) & acc_in_buf;
      end
   end
endmodule

// File: rtl/dsr_stack_chk.sv
module dsr_stack_chk #(
   parameter int AW = 7
) (
   input logic          clk,
   input logic          rst_n,
   input logic          call_i,
   input logic          ret_i,
   input logic          push_i,
   input logic          pop_i,
   input logic          ld_psp_i,
   input logic          ld_dsp_i,
   input logic [AW-1:0] ld_val_i,
   input logic [AW-1:0] psp_o,
   input logic [AW-1:0] dsp_o,
   input logic          ep_hit_o
);
   localparam logic [AW-1:0] K1 = AW'(1);
   localparam logic [AW-1:0] K2 = AW'(2);

   // R2
   call_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (call_i && !ld_psp_i) |=> (psp_o == $past(psp_o) + K2));

   // R3
   ret_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_i && !call_i && !ld_psp_i) |=> (psp_o == $past(psp_o) - K2));

   // R4
   push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !call_i && !ret_i && !ld_dsp_i) |=> (dsp_o == $past(dsp_o) - K1));

   // R5
   pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !push_i && !call_i && !ret_i && !ld_dsp_i) |=> (dsp_o == $past(dsp_o) + K1));

   // R7
   flag_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(push_i || pop_i) |=> !ep_hit_o);

   // R9
   collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((call_i || ret_i) && !ld_dsp_i) |=> ($stable(dsp_o) && !ep_hit_o));

   // R11
   ld_dsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_dsp_i |=> (dsp_o == $past(ld_val_i)));

   // R11
   ld_psp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_psp_i |=> (psp_o == $past(ld_val_i)));
endmodule

bind dsr_stack_ctrl dsr_stack_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
   .push_i(push_i), .pop_i(pop_i), .ld_psp_i(ld_psp_i), .ld_dsp_i(ld_dsp_i),
   .ld_val_i(ld_val_i), .psp_o(psp_o), .dsp_o(dsp_o), .ep_hit_o(ep_hit_o)
);

// File: tb/dsr_stack_ctrl_bench.sv
`timescale 1ns/100ps
module dsr_stack_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        call_r = 0, ret_r = 0, push_r = 0, pop_r = 0;
   logic [7:0]  pdat_r = 0;
   logic [15:0] radr_r = 0;
   logic        ldp_r = 0, ldd_r = 0;
   logic [6:0]  lval_r = 0;
   logic [7:0]  pop_data;
   logic [15:0] ret_addr;
   logic [6:0]  psp, dsp;
   logic        ep_hit;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   dsr_stack_ctrl u_dsr_stack_ctrl (
      .clk(clk), .rst_n(rst_n), .call_i(call_r), .ret_i(ret_r),
      .push_i(push_r), .pop_i(pop_r), .push_data_i(pdat_r),
      .ret_addr_i(radr_r), .ld_psp_i(ldp_r), .ld_dsp_i(ldd_r),
      .ld_val_i(lval_r), .pop_data_o(pop_data), .ret_addr_o(ret_addr),
      .psp_o(psp), .dsp_o(dsp), .ep_hit_o(ep_hit)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // Drive one cycle of strobes from a negedge, return at the next negedge
   task automatic cyc(input bit c, input bit r, input bit pu, input bit po,
                      input logic [7:0] d, input logic [15:0] ra,
                      input bit lp, input bit ld, input logic [6:0] lv);
      call_r = c; ret_r = r; push_r = pu; pop_r = po;
      pdat_r = d; radr_r = ra; ldp_r = lp; ldd_r = ld; lval_r = lv;
      @(negedge clk);
      call_r = 0; ret_r = 0; push_r = 0; pop_r = 0; ldp_r = 0; ldd_r = 0;
   endtask

   task automatic do_push(input logic [7:0] d); cyc(0,0,1,0,d,0,0,0,0); endtask
   task automatic do_pop();                      cyc(0,0,0,1,0,0,0,0,0); endtask
   task automatic do_call(input logic [15:0] a); cyc(1,0,0,0,0,a,0,0,0); endtask
   task automatic do_ret();                      cyc(0,1,0,0,0,0,0,0,0); endtask
   task automatic ld_dsp(input logic [6:0] v);   cyc(0,0,0,0,0,0,0,1,v); endtask
   task automatic ld_psp(input logic [6:0] v);   cyc(0,0,0,0,0,0,1,0,v); endtask
   task automatic idle();                        cyc(0,0,0,0,0,0,0,0,0); endtask

   task automatic t_reset();
      chk("R1 psp", psp, 0);
      chk("R1 dsp", dsp, 0);
      chk("R1 flag", ep_hit, 0);
      chk("R1 pop data", pop_data, 0);
      chk("R1 ret addr", ret_addr, 0);
   endtask

   task automatic t_wrap_push();
      do_push(8'hA5);
      chk("R6 dsp wraps to 0x7F", dsp, 'h7F);
      chk("R7 flag after push at 0x7F", ep_hit, 1);
      idle();
      chk("R7 flag lasts one cycle", ep_hit, 0);
      do_pop();
      chk("R5 pop data", pop_data, 'hA5);
      chk("R6 dsp wraps to 0x00", dsp, 0);
      chk("R7 flag after pop at 0x7F", ep_hit, 1);
      ld_dsp(7'h71);
      do_push(8'h00);
      chk("R7 flag at buffer base 0x70", ep_hit, 1);
   endtask

   task automatic t_remap();
      ld_dsp(7'h70);
      chk("R11 dsp load", dsp, 'h70);
      do_push(8'h11);
      chk("R8 first push address", dsp, 'h6F);
      chk("R8 no flag below buffer", ep_hit, 0);
      do_push(8'h22);
      chk("R4 second push", dsp, 'h6E);
      do_pop();
      chk("R5 last in first out", pop_data, 'h22);
      chk("R5 dsp after pop", dsp, 'h6F);
      do_pop();
      chk("R4 byte at 0x6F", pop_data, 'h11);
      chk("R5 dsp back at 0x70", dsp, 'h70);
   endtask

   task automatic t_call_ret();
      do_call(16'h1234);
      chk("R2 psp after call", psp, 2);
      do_call(16'hBEEF);
      chk("R2 psp after second call", psp, 4);
      do_ret();
      chk("R3 psp after ret", psp, 2);
      chk("R3 ret addr", ret_addr, 'hBEEF);
      do_ret();
      chk("R3 psp back at 0", psp, 0);
      chk("R3 first ret addr", ret_addr, 'h1234);
      ld_dsp(7'h00);
      do_pop();
      chk("R2 low byte at pointer", pop_data, 'h34);
      chk("R7 no flag at 0x00", ep_hit, 0);
      do_pop();
      chk("R2 high byte at pointer+1", pop_data, 'h12);
   endtask

   task automatic t_ret_wrap();
      ld_dsp(7'h00);
      do_push(8'hC3);
      do_push(8'h3C);
      do_ret();
      chk("R6 psp wraps down", psp, 'h7E);
      chk("R6 ret addr from 0x7E/0x7F", ret_addr, 'hC33C);
      do_call(16'h5A6B);
      chk("R6 psp wraps up", psp, 0);
      do_ret();
      chk("R6 ret addr across wrap", ret_addr, 'h5A6B);
      ld_psp(7'h00);
      chk("R11 psp load", psp, 0);
   endtask

   task automatic t_collide();
      ld_dsp(7'h41);
      do_push(8'h77);
      cyc(1,0,1,0,8'h99,16'h0102,0,0,0);
      chk("R9 call proceeds", psp, 2);
      chk("R9 push dropped, dsp holds", dsp, 'h40);
      chk("R9 no flag", ep_hit, 0);
      do_pop();
      chk("R9 push did not write", pop_data, 'h77);
      cyc(0,1,0,1,0,0,0,0,0);
      chk("R9 ret proceeds", ret_addr, 'h0102);
      chk("R9 pop dropped, dsp holds", dsp, 'h41);
      chk("R9 pop data holds", pop_data, 'h77);
   endtask

   task automatic t_same_ptr();
      cyc(0,0,1,1,8'h55,0,0,0,0);
      chk("R10 push wins over pop", dsp, 'h40);
      do_pop();
      chk("R10 pushed byte stored", pop_data, 'h55);
      cyc(1,1,0,0,0,16'hABCD,0,0,0);
      chk("R10 call wins over ret", psp, 2);
      do_ret();
      chk("R10 call stored address", ret_addr, 'hABCD);
   endtask

   task automatic t_load_override();
      ld_dsp(7'h20);
      do_push(8'h44);
      cyc(0,0,1,0,8'hEE,0,0,1,7'h20);
      chk("R11 load beats push", dsp, 'h20);
      chk("R11 no flag", ep_hit, 0);
      ld_dsp(7'h1F);
      do_pop();
      chk("R11 overridden push did not write", pop_data, 'h44);
      cyc(1,0,0,0,0,16'h9999,1,0,7'h10);
      chk("R11 load beats call", psp, 'h10);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_wrap_push();
      t_remap();
      t_call_ret();
      t_ret_wrap();
      t_collide();
      t_same_ptr();
      t_load_override();
      if (!done) begin
         done = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule